// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers per-endpoint events from a set of transmit and receive queue engines and presents them to software as sticky status bits behind a small register port. Completion events for both directions share one status word: transmit endpoints sit in the lower half and receive endpoints in the upper half, each at a bit position equal to its endpoint number. Error events are kept in three per-endpoint error words. A derived summary word shows, for each error class, whether any enabled endpoint has that error pending.

Every status word has a companion enable word. Status bits set on an event and stay set until software writes a one to that bit. The single interrupt line is the registered OR of the enabled completion bits and the enabled summary bits. Endpoint 0 is never served by the queue engines, so its bit positions are held at zero everywhere.

Top module: `qirq_aggregator`

## Requirements
- R1: After reset every status word, every enable word and the summary word read 0, and `irq` is low.
- R2: A one-cycle pulse on bit e (e >= 1) of `tx_done_ev` sets bit e of the completion word (offset 0x00), and on `rx_done_ev` sets bit 16+e. The bit stays set until it is cleared by software.
- R3: Events on endpoint 0 and on endpoints at or above NUM_EP are ignored. Bits 0 and 16 and all bits above the implemented endpoints read 0 in every status and enable word.
- R4: A write to a status word clears exactly the bits written as one. Bits written as zero keep their value.
- R5: An event that arrives in the same cycle as a write-one-to-clear of its bit leaves that bit set.
- R6: Error words are write-one-to-clear and are laid out as follows. Offset 0x08 holds the transmit checksum error of endpoint e at bit e and the transmit length error at bit 16+e. Offset 0x10 holds the receive checksum error at bit e and the receive length error at bit 16+e. Offset 0x18 holds the receive zero-length event at bit e.
- R7: The summary word at offset 0x20 has bit 0 for receive checksum, bit 1 for receive length, bit 2 for receive zero-length, bit 3 for transmit checksum and bit 4 for transmit length. Each summary bit is the OR, over endpoints, of the error bits of its class ANDed with the per-endpoint enable bits. A summary bit falls as soon as the underlying error bits are cleared.
- R8: `irq` goes high one clock after any status bit ANDed with its enable becomes nonzero: the completion word with its enable at 0x04, or the summary with its enable at 0x24. `irq` falls one clock after that condition ends.
- R9: The enable words (0x04, 0x0C, 0x14, 0x1C, 0x24) read back the last value written, restricted to their implemented bits. A write to the summary word at 0x20 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_done_ev | input | NUM_EP | Transmit completion pulses, one bit per endpoint |
| rx_done_ev | input | NUM_EP | Receive completion pulses |
| tx_cks_err_ev | input | NUM_EP | Transmit checksum error pulses |
| tx_len_err_ev | input | NUM_EP | Transmit length error pulses |
| rx_cks_err_ev | input | NUM_EP | Receive checksum error pulses |
| rx_len_err_ev | input | NUM_EP | Receive length error pulses |
| rx_zlp_ev | input | NUM_EP | Receive zero-length packet pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every endpoint of a four-endpoint configuration through every event class. For each case it checks the exact bit position that is set, which catches a design that swaps the transmit and receive halves or shifts endpoints by one. It also checks that endpoint 0 stays silent, which a design with a wrong valid mask would fail. Each summary bit is checked with its per-endpoint enables off and then on, so a design that ORs raw error bits, or maps a class to the wrong summary position, is caught. The bench aims at the cycle where a clear and a new event collide, where a design that lets the clear win would lose the event. It also checks the exact cycle in which `irq` rises and falls, which an unregistered or doubly registered output would get wrong.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int DW     = 32;
    localparam int HW     = 16;
    localparam int AW     = 6;
    localparam int NBANK  = 4;
    localparam int NCLASS = 5;

    // register byte offsets: bank b status at 8*b, its enable at 8*b+4
    localparam logic [AW-1:0] OFF_SUM    = 6'h20;
    localparam logic [AW-1:0] OFF_SUM_EN = 6'h24;

    // summary layout, packed MSB first: tx_len=4 .. rx_cks=0
    typedef struct packed {
        logic tx_len;
        logic tx_cks;
        logic rx_zlp;
        logic rx_len;
        logic rx_cks;
    } exc_sum_t;

    typedef struct packed {
        logic irq;
    } top_state_t;

    function automatic logic [HW-1:0] ep_mask(int n_ep);
        logic [HW-1:0] m;
        m = '0;
        for (int i = 1; i < HW; i++) begin
            if (i < n_ep) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] bank_mask(int b, int n_ep);
        logic [HW-1:0] em;
        em = ep_mask(n_ep);
        if (b == 3) return {{HW{1'b0}}, em};
        return {em, em};
    endfunction

    function automatic logic [AW-1:0] stat_off(int b);
        return AW'(8 * b);
    endfunction

    function automatic logic [AW-1:0] en_off(int b);
        return AW'(8 * b + 4);
    endfunction

endpackage

// File: rtl/qirq_sticky.sv
module qirq_sticky #(
    parameter int          W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set dominates clear so a colliding event is never lost
        st_d.bits = ((st_q.bits & ~clr_i) | set_i) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/qirq_enreg.sv
module qirq_enreg #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.bits = wdata_i & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/qirq_summary.sv
module qirq_summary
    import qirq_pkg::*;
(
    input  logic [DW-1:0] tx_err_i,
    input  logic [DW-1:0] tx_en_i,
    input  logic [DW-1:0] rx_err_i,
    input  logic [DW-1:0] rx_en_i,
    input  logic [DW-1:0] zlp_i,
    input  logic [DW-1:0] zlp_en_i,
    output exc_sum_t      sum_o
);

    logic [DW-1:0] tx_hit, rx_hit, zlp_hit;

    always_comb begin
        tx_hit  = tx_err_i & tx_en_i;
        rx_hit  = rx_err_i & rx_en_i;
        zlp_hit = zlp_i & zlp_en_i;

        sum_o        = '0;
        sum_o.rx_cks = |rx_hit[HW-1:0];
        sum_o.rx_len = |rx_hit[DW-1:HW];
        sum_o.rx_zlp = |zlp_hit;
        sum_o.tx_cks = |tx_hit[HW-1:0];
        sum_o.tx_len = |tx_hit[DW-1:HW];
    end

endmodule

// File: rtl/qirq_aggregator.sv
module qirq_aggregator
    import qirq_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_EP-1:0] tx_done_ev,
    input  logic [NUM_EP-1:0] rx_done_ev,
    input  logic [NUM_EP-1:0] tx_cks_err_ev,
    input  logic [NUM_EP-1:0] tx_len_err_ev,
    input  logic [NUM_EP-1:0] rx_cks_err_ev,
    input  logic [NUM_EP-1:0] rx_len_err_ev,
    input  logic [NUM_EP-1:0] rx_zlp_ev,
    output logic              irq
);

    localparam logic [NCLASS-1:0] SUM_VALID = '1;

    // bank 0: completions, 1: transmit errors, 2: receive errors, 3: zero-length
    logic [DW-1:0] st_set [NBANK];
    logic [DW-1:0] st_clr [NBANK];
    logic [DW-1:0] st_q   [NBANK];
    logic [DW-1:0] en_q   [NBANK];

    logic [NCLASS-1:0] sum_en_q;
    exc_sum_t          sum;
    logic [DW-1:0]     done_stat, done_en;
    logic [NCLASS-1:0] sum_bits;

    top_state_t ts_d, ts_q;

    always_comb begin
        st_set[0] = {HW'(rx_done_ev),    HW'(tx_done_ev)};
        st_set[1] = {HW'(tx_len_err_ev), HW'(tx_cks_err_ev)};
        st_set[2] = {HW'(rx_len_err_ev), HW'(rx_cks_err_ev)};
        st_set[3] = {{HW{1'b0}},         HW'(rx_zlp_ev)};
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign st_clr[g] = (reg_wr && reg_addr == stat_off(g)) ? reg_wdata : '0;

        qirq_sticky #(
            .W     (DW),
            .VALID (bank_mask(g, NUM_EP))
        ) u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (st_set[g]),
            .clr_i (st_clr[g]),
            .q_o   (st_q[g])
        );

        qirq_enreg #(
            .W     (DW),
            .VALID (bank_mask(g, NUM_EP))
        ) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (reg_wr && reg_addr == en_off(g)),
            .wdata_i (reg_wdata),
            .q_o     (en_q[g])
        );
    end

    qirq_enreg #(
        .W     (NCLASS),
        .VALID (SUM_VALID)
    ) u_sum_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_wr && reg_addr == OFF_SUM_EN),
        .wdata_i (reg_wdata[NCLASS-1:0]),
        .q_o     (sum_en_q)
    );

    qirq_summary u_sum (
        .tx_err_i (st_q[1]),
        .tx_en_i  (en_q[1]),
        .rx_err_i (st_q[2]),
        .rx_en_i  (en_q[2]),
        .zlp_i    (st_q[3]),
        .zlp_en_i (en_q[3]),
        .sum_o    (sum)
    );

    assign done_stat = st_q[0];
    assign done_en   = en_q[0];
    assign sum_bits  = sum;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (reg_addr == stat_off(b)) reg_rdata = st_q[b];
            if (reg_addr == en_off(b))   reg_rdata = en_q[b];
        end
        if (reg_addr == OFF_SUM)    reg_rdata = DW'(sum_bits);
        if (reg_addr == OFF_SUM_EN) reg_rdata = DW'(sum_en_q);
    end

    // interrupt request, registered one cycle
    always_comb begin
        ts_d     = ts_q;
        ts_d.irq = (|(done_stat & done_en)) | (|(sum_bits & sum_en_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign irq = ts_q.irq;

endmodule

// File: rtl/qirq_aggregator_chk.sv
module qirq_aggregator_chk
    import qirq_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [NUM_EP-1:0] tx_done_ev,
    input logic [NUM_EP-1:0] rx_done_ev,
    input logic [DW-1:0]     done_stat,
    input logic [DW-1:0]     done_en,
    input logic [DW-1:0]     err_tx,
    input logic [DW-1:0]     err_rx,
    input logic [DW-1:0]     err_zlp,
    input logic [NCLASS-1:0] sum_bits,
    input logic [NCLASS-1:0] sum_en,
    input logic              irq
);

    localparam logic [HW-1:0] EMASK = ep_mask(NUM_EP);

    logic [DW-1:0] ev_word;
    logic          wr_done;
    assign ev_word = {HW'(rx_done_ev) & EMASK, HW'(tx_done_ev) & EMASK};
    assign wr_done = reg_wr && (reg_addr == 6'h00);

    // R2: a set completion bit stays set unless the completion word is written
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> ((done_stat & $past(done_stat)) == $past(done_stat)));

    // R3: endpoint 0 positions never hold a bit
    p_ep0_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stat[0] == 1'b0) && (done_stat[HW] == 1'b0) && (err_zlp[DW-1:HW] == '0));

    // R4: a clear with no colliding event removes every written bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && ev_word == '0) |=> ((done_stat & $past(reg_wdata)) == '0));

    // R5: every valid event is present in the next cycle whatever is written
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((done_stat & $past(ev_word)) == $past(ev_word)));

    // R7: no summary bit without an error bit behind it
    p_sum_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tx == '0 && err_rx == '0 && err_zlp == '0) |-> (sum_bits == '0));

    // R8: interrupt is the enabled condition of the previous cycle
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past((|(done_stat & done_en)) || (|(sum_bits & sum_en)))));

endmodule

bind qirq_aggregator qirq_aggregator_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tx_done_ev (tx_done_ev),
    .rx_done_ev (rx_done_ev),
    .done_stat  (done_stat),
    .done_en    (done_en),
    .err_tx     (st_q[1]),
    .err_rx     (st_q[2]),
    .err_zlp    (st_q[3]),
    .sum_bits   (sum_bits),
    .sum_en     (sum_en_q),
    .irq        (irq)
);

// File: tb/qirq_aggregator_bench.sv
module qirq_aggregator_bench;

    localparam int N = 4;
    localparam logic [15:0] EM = 16'h000E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  ev [7];
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    qirq_aggregator #(.NUM_EP(N)) u_qirq_aggregator (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tx_done_ev    (ev[0]),
        .rx_done_ev    (ev[1]),
        .rx_cks_err_ev (ev[2]),
        .rx_len_err_ev (ev[3]),
        .rx_zlp_ev     (ev[4]),
        .tx_cks_err_ev (ev[5]),
        .tx_len_err_ev (ev[6]),
        .irq           (irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(int k, int e);
        @(negedge clk);
        ev[k][e] = 1'b1;
        @(negedge clk);
        ev[k] = '0;
    endtask

    // event kinds 0 tx done, 1 rx done, then error classes 2..6 map to summary bit k-2
    function automatic logic [5:0] kind_addr(int k);
        case (k)
            0, 1:    return 6'h00;
            2, 3:    return 6'h10;
            4:       return 6'h18;
            default: return 6'h08;
        endcase
    endfunction

    function automatic int kind_pos(int k, int e);
        case (k)
            1, 3, 6: return 16 + e;
            default: return e;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run complete)");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        for (int k = 0; k < 7; k++) ev[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state of every register
        for (int a = 0; a < 10; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 R3 R4 sweep of completion events, no enables
        for (int k = 0; k < 2; k++) begin
            for (int e = 0; e < N; e++) begin
                pulse(k, e);
                rd(6'h00, v);
                exp = (e == 0) ? 32'h0 : (32'h1 << kind_pos(k, e));
                chk(e == 0 ? "R3 endpoint 0 ignored" : "R2 completion bit", v, exp);
                chk("R8 irq masked", {31'b0, irq}, 32'h0);
                wr(6'h00, ~exp);
                rd(6'h00, v);
                chk("R4 zero bits keep value", v, exp);
                wr(6'h00, exp);
                rd(6'h00, v);
                chk("R4 one bits clear", v, 32'h0);
            end
        end

        // R9 enable readback, summary write ignored
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, v);
        chk("R9 completion enable readback", v, {EM, EM});
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, v);
        chk("R9 summary write ignored", v, 32'h0);

        // R8 irq timing on completion
        pulse(0, 2);
        chk("R8 irq not before one cycle", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq rises", {31'b0, irq}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h4;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 irq held in clear cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 irq falls", {31'b0, irq}, 32'h0);

        // R5 set and clear in the same cycle
        pulse(1, 3);
        @(negedge clk);
        ev[1][3] = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h0008_0000;
        @(negedge clk);
        ev[1] = '0; reg_wr = 1'b0;
        rd(6'h00, v);
        chk("R5 event wins over clear", v, 32'h0008_0000);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'h0);

        // R6 R7 R8 error sweep, pass 0 enables off, pass 1 enables on
        for (int p = 0; p < 2; p++) begin
            wr(6'h0C, p == 1 ? 32'hFFFF_FFFF : 32'h0);
            wr(6'h14, p == 1 ? 32'hFFFF_FFFF : 32'h0);
            wr(6'h1C, p == 1 ? 32'hFFFF_FFFF : 32'h0);
            wr(6'h24, p == 1 ? 32'h1F : 32'h0);
            for (int k = 2; k < 7; k++) begin
                for (int e = 0; e < N; e++) begin
                    pulse(k, e);
                    rd(kind_addr(k), v);
                    exp = (e == 0) ? 32'h0 : (32'h1 << kind_pos(k, e));
                    chk(e == 0 ? "R3 endpoint 0 error ignored" : "R6 error bit", v, exp);
                    rd(6'h20, v);
                    chk("R7 summary bit", v,
                        (p == 1 && e != 0) ? (32'h1 << (k - 2)) : 32'h0);
                    chk("R8 irq from summary", {31'b0, irq},
                        (p == 1 && e != 0) ? 32'h1 : 32'h0);
                    wr(kind_addr(k), exp);
                    rd(6'h20, v);
                    chk("R7 summary clears", v, 32'h0);
                    chk("R8 irq drops", {31'b0, irq}, 32'h0);
                end
            end
        end
        rd(6'h1C, v);
        chk("R9 zero-length enable readback", v, {16'h0, EM});
        rd(6'h24, v);
        chk("R9 summary enable readback", v, 32'h1F);

        finish_run();
    end

endmodule